// File: doc/BRIEF.md
# Bus Initiator Latency Timer

This block bounds how long a bus initiator may keep a burst going. Host software programs an 8-bit latency value, counted in bus clock cycles. When the initiator raises its frame signal, the block copies the programmed value into a working limit and starts counting cycles. Once the elapsed count reaches that limit, the block raises a stop request towards the initiator's transaction sequencer.

The burst is not cut at the moment of expiry. The stop request stays high until the next data phase completes, and the sequencer then drops frame. A transaction that ends on its own before expiry clears the counter, and the timer arms again on the next frame assertion. A setting of zero gives the earliest possible cutoff. Settings of 20h or more let most transfers complete.

Top module: `lat_timer`

## Requirements
- R1: After reset, the latency register reads 00h and stop_req is low.
- R2: A cycle with wr_en high loads all 8 bits of wr_data into the latency register, and rd_data shows the new value from the next cycle on.
- R3: The cycle after frame_start is sampled is active cycle 0. The elapsed count is 0 there and grows by one in each following active cycle.
- R4: With a captured limit N, stop_req is low in active cycles 0 to N-1 and first goes high in active cycle N, provided no done strobe intervenes.
- R5: With a captured limit of 0, stop_req is high in active cycle 0.
- R6: Once high, stop_req stays high until a cycle with phase_done high; it is low in the cycle after that one. A phase_done pulse before expiry has no effect on the count or on stop_req.
- R7: xfer_done in an active cycle ends the transaction. stop_req is then low, and no count runs, until the next frame_start.
- R8: The limit is captured at frame_start from the register value held before any write in that same cycle. A write during an active transaction changes rd_data but not the running limit.
- R9: frame_start during an active transaction restarts the count at 0 with the current register value. In the same cycle it takes priority over phase_done and xfer_done.
- R10: The elapsed count saturates at 255, so a limit of FFh expires in active cycle 255 and stop_req stays high afterwards until phase_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Latency register write strobe |
| wr_data | input | 8 | Latency register write value |
| frame_start | input | 1 | Pulse: initiator asserts frame |
| phase_done | input | 1 | Pulse: a data phase completed |
| xfer_done | input | 1 | Pulse: transaction ended normally |
| rd_data | output | 8 | Latency register readback |
| stop_req | output | 1 | Request to end burst at close of current data phase |

## Verification
The assertions assume that frame_start is a single-cycle pulse and that phase_done and xfer_done mean something only while a transaction is active. The design still tolerates these strobes when idle, and the assertions carry enable terms so that they cannot misfire there. The random stimulus raises frame_start only as one-cycle pulses. It draws the done strobes at moderate rates so that bursts run out, get cut or end normally in roughly equal measure. Directed bursts pin down the boundary cycles for limits 0, 3, 20h and FFh.

// File: rtl/lat_timer_pkg.sv
package lat_timer_pkg;
  localparam int unsigned LT_W = 8;

  // Saturating increment of an elapsed-cycle count.
  function automatic logic [LT_W-1:0] sat_inc(input logic [LT_W-1:0] v);
    return (v == {LT_W{1'b1}}) ? v : v + 1'b1;
  endfunction

  // Expiry test: elapsed count has reached or passed the limit.
  function automatic logic is_expired(input logic [LT_W-1:0] cnt,
                                      input logic [LT_W-1:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/lt_cfg_reg.sv
module lt_cfg_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         capture,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] limit_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      limit_q <= '0;
    end else begin
      if (capture) limit_q <= cfg_q;
      if (wr_en)   cfg_q   <= wr_data;
    end
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_q == $past(wr_data));
  a_r8_limit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> limit_q == $past(limit_q));
  a_r8_capture_old: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> limit_q == $past(cfg_q));
endmodule

// File: rtl/lt_counter.sv
module lt_counter
  import lat_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            finish,
  output logic            active,
  output logic [LT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      count  <= '0;
    end else if (start) begin
      active <= 1'b1;
      count  <= '0;
    end else if (active && finish) begin
      active <= 1'b0;
      count  <= '0;
    end else if (active) begin
      count  <= sat_inc(count);
    end
  end

  a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active && count == '0);
  a_r3_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
    active && !start && !finish |=> active && count >= $past(count));
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> count == '0);
endmodule

// File: rtl/lt_stop.sv
module lt_stop
  import lat_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [LT_W-1:0] count,
  input  logic [LT_W-1:0] limit,
  input  logic            phase_done,
  output logic            stop_req,
  output logic            cut_evt
);
  always_comb begin
    stop_req = active && is_expired(count, limit);
    cut_evt  = stop_req && phase_done;
  end

  a_r5_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    active && limit == '0 |-> stop_req);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !stop_req);
endmodule

// File: rtl/lat_timer.sv
module lat_timer
  import lat_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [LT_W-1:0] wr_data,
  input  logic            frame_start,
  input  logic            phase_done,
  input  logic            xfer_done,
  output logic [LT_W-1:0] rd_data,
  output logic            stop_req
);
  logic            active;
  logic [LT_W-1:0] count;
  logic [LT_W-1:0] limit_q;
  logic            cut_evt;
  logic            end_evt;

  assign end_evt = xfer_done || cut_evt;

  lt_cfg_reg #(.W(LT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .capture(frame_start), .cfg_q(rd_data), .limit_q(limit_q)
  );

  lt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .finish(end_evt),
    .active(active), .count(count)
  );

  lt_stop u_stop (
    .clk(clk), .rst_n(rst_n), .active(active), .count(count),
    .limit(limit_q), .phase_done(phase_done), .stop_req(stop_req),
    .cut_evt(cut_evt)
  );

  a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && !phase_done && !xfer_done && !frame_start |=> stop_req);
  a_r6_cut_ends: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && phase_done && !frame_start |=> !stop_req && !active);
  a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    active && xfer_done && !frame_start |=> !stop_req);
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> active && count == '0);
endmodule

// File: tb/sim_lat_timer.sv
module sim_lat_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       frame_start = 1'b0;
  logic       phase_done = 1'b0;
  logic       xfer_done = 1'b0;
  logic [7:0] rd_data;
  logic       stop_req;

  int n_chk = 0;
  int n_bad = 0;

  // bench reference state
  logic       m_act = 1'b0;
  int         m_cnt = 0;
  logic [7:0] m_lim = '0;
  logic [7:0] m_reg = '0;
  logic       last_stop;

  always #2.5 clk = ~clk;

  lat_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .frame_start(frame_start), .phase_done(phase_done),
    .xfer_done(xfer_done), .rd_data(rd_data), .stop_req(stop_req)
  );

  function automatic logic exp_stop(logic act, int cnt, logic [7:0] lim);
    return act && (cnt >= int'(lim));
  endfunction

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // One cycle: drive at negedge, compare outputs, advance the reference.
  task automatic cyc(logic we, logic [7:0] wd, logic fs, logic pd, logic xd);
    logic s;
    @(negedge clk);
    wr_en = we; wr_data = wd; frame_start = fs; phase_done = pd; xfer_done = xd;
    #1;
    s = exp_stop(m_act, m_cnt, m_lim);
    last_stop = stop_req;
    check("R4 stop_req", int'(stop_req), int'(s));
    check("R2 rd_data", int'(rd_data), int'(m_reg));
    if (fs) begin
      m_act = 1'b1; m_cnt = 0; m_lim = m_reg;
    end else if (m_act && (xd || (s && pd))) begin
      m_act = 1'b0; m_cnt = 0;
    end else if (m_act) begin
      m_cnt = (m_cnt == 255) ? 255 : m_cnt + 1;
    end
    if (we) m_reg = wd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  // Start a burst and return the first active cycle index with stop_req high.
  task automatic first_stop(output int idx);
    idx = -1;
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 300 && idx < 0; i++) begin
      cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
      if (last_stop) idx = i;
    end
  endtask

  initial begin
    int idx;
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int idx;
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rd_data", int'(rd_data), 0);
    check("R1 reset stop_req", int'(stop_req), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2: write and read back an all-bits pattern
    cyc(1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
    idle(1);
    check("R2 readback", int'(rd_data), 8'hA5);

    // R5: zero limit stops in active cycle 0
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    first_stop(idx);
    check("R5 zero limit first stop", idx, 0);
    // R6: stop held without phase_done, cut by phase_done
    idle(3);
    check("R6 stop held", int'(last_stop), 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    idle(1);
    check("R6 stop dropped after phase_done", int'(last_stop), 0);

    // R4/R3: limit 3 expires in active cycle 3
    cyc(1'b1, 8'h03, 1'b0, 1'b0, 1'b0);
    first_stop(idx);
    check("R4 limit 3 first stop", idx, 3);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);

    // R4: recommended 20h
    cyc(1'b1, 8'h20, 1'b0, 1'b0, 1'b0);
    first_stop(idx);
    check("R4 limit 20h first stop", idx, 32);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);

    // R6: phase_done before expiry has no effect
    cyc(1'b1, 8'h05, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    idle(2);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R6 early phase_done ignored (cycle 4 low)", int'(last_stop), 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R6 early phase_done ignored (cycle 5 high)", int'(last_stop), 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);

    // R7: normal end clears, no stop until re-armed
    cyc(1'b1, 8'h02, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    idle(5);
    check("R7 idle after xfer_done", int'(last_stop), 0);

    // R8: write during burst leaves running limit alone, same-cycle write too
    cyc(1'b1, 8'h04, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 8'h00, 1'b1, 1'b0, 1'b0);
    cyc(1'b1, 8'h01, 1'b0, 1'b0, 1'b0);
    check("R8 first cycle uses old limit 4", int'(last_stop), 0);
    idle(2);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R8 cycle 3 still low", int'(last_stop), 0);
    check("R8 readback shows new value", int'(rd_data), 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R8 cycle 4 high", int'(last_stop), 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);

    // R9: restart mid-burst with new value, priority over xfer_done
    cyc(1'b1, 8'h06, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    idle(2);
    cyc(1'b1, 8'h02, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    idle(2);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R9 restart cycle 2 stop", int'(last_stop), 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);

    // R10: limit FFh and saturation
    cyc(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    first_stop(idx);
    check("R10 limit FFh first stop", idx, 255);
    idle(10);
    check("R10 saturated stop held", int'(last_stop), 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);

    // random mix, reference-checked every cycle
    for (int i = 0; i < 4000; i++) begin
      logic we, fs, pd, xd;
      v  = 8'($urandom_range(0, 12));
      we = ($urandom_range(0, 9) == 0);
      fs = ($urandom_range(0, 14) == 0);
      pd = m_act && ($urandom_range(0, 3) == 0);
      xd = m_act && ($urandom_range(0, 19) == 0);
      cyc(we, v, fs, pd, xd);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule